// File: doc/BRIEF.md
# Serial Command Register Interface

This block is the slave side of the control port of a radio transceiver. A host microcontroller sends 16-bit command words over a four-wire serial link: a serial clock, a data input, an active-low select and a data output. The block oversamples these pins with its own system clock and shifts in one data bit on each rising serial clock while the select is low. It sorts each word by the prefix in its leading bits and then updates the register that the prefix names. The register contents appear only as output ports, and the rest of the chip reads them from there.

A word whose first bit is 0 is a status read. For the rest of that frame the block returns a status word on the data output. A write takes effect when the select returns high, and only when exactly sixteen bits were clocked in. A shorter, longer or abandoned frame leaves every register as it was. The frequency word is checked against a legal range, and a value outside that range is dropped without any change. The block also derives an on-time count for low duty-cycle operation from the duty register and the wake-up period register.

Top module: `radio_cmd_port`

## Requirements
- R1: After reset, freq_word is 0x680, duty_d is 7, duty_en is 0, wake_m is 0x96, wake_r is 1, on_count is 15 and spi_miso is 0.
- R2: A 16-bit word sent MSB first with bits 15..12 equal to 1010 loads bits 11..0 into freq_word when the select rises.
- R3: A frequency value below 96 or above 3903 leaves freq_word unchanged and sets the reject flag. An accepted value clears that flag. 96 and 3903 are both accepted.
- R4: A write frame of any length other than 16 bits (for example 15 or 17) changes no register.
- R5: A word with bits 15..8 equal to 0xC8 loads bits 7..1 into duty_d and bit 0 into duty_en.
- R6: A word with bits 15..13 equal to 111 loads bits 12..8 into wake_r and bits 7..0 into wake_m.
- R7: on_count equals 2*duty_d+1, limited to at most wake_m.
- R8: A frame whose first bit is 0 is a status read. On each falling serial clock edge after the first bit, spi_miso presents the next status bit, MSB first, of the 15-bit word {reject flag, duty_en, 0, freq_word[11:0]}. The host therefore sees status bits 14..0 on rising edges 2 to 16.
- R9: spi_miso holds its last value while the select is high and during write frames.
- R10: A 16-bit write whose prefix matches no command changes no register.
- R11: A select rising in mid-frame discards the partial bits, and serial clock edges while deselected are ignored. The next full frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial status data out |
| freq_word | output | 12 | Stored frequency value |
| duty_d | output | 7 | Duty-cycle D field |
| duty_en | output | 1 | Low duty-cycle enable |
| wake_m | output | 8 | Wake-up period mantissa M |
| wake_r | output | 5 | Wake-up period exponent R |
| on_count | output | 8 | Derived on-time count, min(2D+1, M) |

## Verification
A wrong bit count or a wrong shift register becomes visible at the register ports about three system clocks after the select rises, as a value that was never written or a write that did not happen. A faulty reject flag or a faulty stored frequency shows up only on the next status read, where the host sees the wrong bits in positions 14..0. A fault in the output shift path shows up on the very next falling serial clock of a read. An error in the on-count clamp is visible at once, after any write to the duty register or the wake-up register.

// File: rtl/radio_cmd_port.sv
module radio_cmd_port #(
  parameter logic [11:0] F_LO    = 12'd96,
  parameter logic [11:0] F_HI    = 12'd3903,
  parameter logic [11:0] F_POR   = 12'h680,
  parameter logic [6:0]  D_POR   = 7'd7,
  parameter logic [7:0]  M_POR   = 8'h96,
  parameter logic [4:0]  R_POR   = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [11:0] freq_word,
  output logic [6:0]  duty_d,
  output logic        duty_en,
  output logic [7:0]  wake_m,
  output logic [4:0]  wake_r,
  output logic [7:0]  on_count
);
  localparam int CW = 5;
  localparam logic [CW-1:0] FULL = CW'(16);
  localparam logic [CW-1:0] SAT  = {CW{1'b1}};

  logic [1:0]  sck_q, csn_q, mosi_q;
  logic        sck_d, csn_d;
  logic [15:0] sr;
  logic [CW-1:0] cnt;
  logic        rd_mode;
  logic [14:0] st_sh;
  logic        rej;

  wire sck_s    = sck_q[1];
  wire cs_s     = csn_q[1];
  wire mosi_s   = mosi_q[1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_rise  = cs_s & ~csn_d;
  wire commit   = cs_rise && (cnt == FULL) && sr[15];

  wire [14:0] status = {rej, duty_en, 1'b0, freq_word};
  wire [7:0]  dd     = {duty_d, 1'b1};
  assign on_count    = (dd > wake_m) ? wake_m : dd;

  wire f_ok = (sr[11:0] >= F_LO) && (sr[11:0] <= F_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 2'b00;
      csn_q  <= 2'b11;
      mosi_q <= 2'b00;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sck_q  <= {sck_q[0], spi_sck};
      csn_q  <= {csn_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
      sck_d  <= sck_s;
      csn_d  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      rd_mode  <= 1'b0;
      st_sh    <= '0;
      spi_miso <= 1'b0;
    end else if (cs_s) begin
      cnt     <= '0;
      rd_mode <= 1'b0;
    end else if (sck_rise) begin
      sr <= {sr[14:0], mosi_s};
      if (cnt != SAT) cnt <= cnt + 1'b1;
      if (cnt == '0 && !mosi_s) begin
        rd_mode <= 1'b1;
        st_sh   <= status;
      end
    end else if (sck_fall && rd_mode) begin
      spi_miso <= st_sh[14];
      st_sh    <= {st_sh[13:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word <= F_POR;
      rej       <= 1'b0;
      duty_d    <= D_POR;
      duty_en   <= 1'b0;
      wake_m    <= M_POR;
      wake_r    <= R_POR;
    end else if (commit) begin
      if (sr[15:12] == 4'b1010) begin
        if (f_ok) begin
          freq_word <= sr[11:0];
          rej       <= 1'b0;
        end else begin
          rej <= 1'b1;
        end
      end else if (sr[15:8] == 8'hC8) begin
        duty_d  <= sr[7:1];
        duty_en <= sr[0];
      end else if (sr[15:13] == 3'b111) begin
        wake_r <= sr[12:8];
        wake_m <= sr[7:0];
      end
    end
  end
endmodule

// File: rtl/radio_cmd_port_chk.sv
module radio_cmd_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_s,
  input logic        cs_rise,
  input logic        rd_mode,
  input logic        spi_miso,
  input logic [11:0] freq_word,
  input logic        duty_en,
  input logic [7:0]  on_count,
  input logic [7:0]  wake_m
);
  // R3
  freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_word >= 12'd96 && freq_word <= 12'd3903);

  // R2
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(freq_word));

  // R5
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(duty_en));

  // R7
  on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_count <= wake_m);

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(spi_miso));

  // R8
  miso_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mode |=> $stable(spi_miso));
endmodule

bind radio_cmd_port radio_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
  .rd_mode(rd_mode), .spi_miso(spi_miso), .freq_word(freq_word),
  .duty_en(duty_en), .on_count(on_count), .wake_m(wake_m)
);

// File: tb/sim_radio_cmd_port.sv
module sim_radio_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6 * CLK_PERIOD;

  logic clk = 0, rst_n = 0;
  logic spi_sck = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso;
  logic [11:0] freq_word;
  logic [6:0] duty_d;
  logic duty_en;
  logic [7:0] wake_m, on_count;
  logic [4:0] wake_r;

  radio_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .freq_word(freq_word),
    .duty_d(duty_d), .duty_en(duty_en), .wake_m(wake_m), .wake_r(wake_r),
    .on_count(on_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { string req; int sel; logic [15:0] exp; } item_t;
  item_t q[$];
  bit pend = 0;
  bit done = 0;
  int errors = 0, checks = 0;
  logic [15:0] rd_word = '0;

  logic [11:0] ef = 12'h680;
  logic [6:0]  ed = 7'd7;
  logic        een = 0, erej = 0;
  logic [7:0]  em = 8'h96;
  logic [4:0]  er = 5'd1;

  function automatic logic [15:0] actual(int sel);
    case (sel)
      0: return {4'h0, freq_word};
      1: return {9'h0, duty_d};
      2: return {15'h0, duty_en};
      3: return {8'h0, wake_m};
      4: return {11'h0, wake_r};
      5: return {8'h0, on_count};
      6: return rd_word;
      default: return {15'h0, spi_miso};
    endcase
  endfunction

  initial begin
    forever begin
      wait (pend);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] a;
        it = q.pop_front();
        a = actual(it.sel);
        checks++;
        if (a !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, a, it.exp);
        end
      end
      pend = 0;
    end
  end

  task automatic push(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic go();
    pend = 1;
    wait (!pend);
  endtask

  function automatic logic [7:0] exp_on();
    logic [7:0] dd;
    dd = {ed, 1'b1};
    return (dd > em) ? em : dd;
  endfunction

  task automatic push_regs(input string req);
    push(req, 0, {4'h0, ef});
    push(req, 1, {9'h0, ed});
    push(req, 2, {15'h0, een});
    push(req, 3, {8'h0, em});
    push(req, 4, {11'h0, er});
    push(req, 5, {8'h0, exp_on()});
    go();
  endtask

  task automatic frame(input logic [31:0] w, input int n, output logic [15:0] rx);
    rx = '0;
    spi_cs_n = 0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      spi_mosi = w[n-1-i];
      #(HALF);
      rx = {rx[14:0], spi_miso};
      spi_sck = 1;
      #(HALF);
      spi_sck = 0;
    end
    #(HALF);
    spi_cs_n = 1;
    #(CLK_PERIOD*10);
  endtask

  function automatic void model(input logic [15:0] w);
    if (w[15:12] == 4'b1010) begin
      if (w[11:0] >= 12'd96 && w[11:0] <= 12'd3903) begin ef = w[11:0]; erej = 0; end
      else erej = 1;
    end else if (w[15:8] == 8'hC8) begin
      ed = w[7:1]; een = w[0];
    end else if (w[15:13] == 3'b111) begin
      er = w[12:8]; em = w[7:0];
    end
  endfunction

  task automatic wr(input logic [15:0] w);
    logic [15:0] rx;
    frame({16'h0, w}, 16, rx);
    model(w);
  endtask

  task automatic rd(input string req);
    logic [15:0] rx;
    frame(32'h0, 16, rx);
    rd_word = {1'b0, rx[14:0]};
    push(req, 6, {1'b0, erej, een, 1'b0, ef});
    go();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    #(CLK_PERIOD*3);
    @(posedge clk); #2;
    rst_n = 1;
    #(CLK_PERIOD*4);

    push_regs("R1 reset");
    push("R1 reset miso", 7, 16'h0); go();

    wr(16'hA123); push_regs("R2 freq write");
    wr(16'hA05F); push_regs("R3 F=95 rejected");
    rd("R3 reject flag set / R8 status");
    wr(16'hA060); push_regs("R3 F=96 accepted");
    rd("R3 reject flag cleared / R8 status");
    wr(16'hAF40); push_regs("R3 F=3904 rejected");
    wr(16'hAFFF); push_regs("R3 F=4095 rejected");
    wr(16'hAF3F); push_regs("R3 F=3903 accepted");

    wr(16'hC829); push_regs("R5 duty D=20 en=1 / R7 on=41");
    wr(16'hE31E); push_regs("R6 wake R=3 M=30 / R7 clamp");
    wr(16'hFF00); push_regs("R6 wake M=0 / R7 clamp to 0");
    wr(16'hE1C8); push_regs("R6 wake M=200 / R7 unclamped");

    frame({17'h0, 15'h5255}, 15, rx); push_regs("R4 15-bit frame ignored");
    frame({15'h0, 16'hA255, 1'b1}, 17, rx); push_regs("R4 17-bit frame ignored");

    wr(16'h8123); push_regs("R10 unknown prefix 0x8");
    wr(16'hB200); push_regs("R10 unknown prefix 0xB");
    wr(16'hC900); push_regs("R10 unknown prefix 0xC9");

    frame({24'h0, 8'hA7}, 8, rx);
    spi_sck = 1; #(HALF); spi_sck = 0; #(HALF);
    spi_sck = 1; #(HALF); spi_sck = 0; #(HALF);
    wr(16'hA201); push_regs("R11 partial frame discarded, next frame decoded");

    rd("R8 status after valid writes");

    frame(32'h0, 15, rx);
    push("R9 miso after 15-bit read", 7, {15'h0, ef[0]}); go();
    wr(16'hC802);
    push("R9 miso held through write", 7, {15'h0, ef[0]});
    push_regs("R5 duty D=1 en=0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule